// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block is the bus-facing front end of a small NAND flash device model. On every write strobe it looks at the 8-bit data bus and the command-latch, address-latch, active-low chip-enable and active-low write-protect inputs. From these it captures command bytes and builds the address from the address bytes. It tracks the column offset that the read-region commands select, and it decides when an operation is complete.

When a read, a program setup, a program commit or an erase is complete, the block issues a one-cycle start pulse. With the pulse it gives an operation code and the row and column to a separate page-storage block. It also answers identification and status requests on its own read port. The page geometry is fixed by a parameter. A small-page part takes three address bytes and a 512-byte page. A large-page part takes four address bytes and a 2048-byte page, and it accepts three more commands: read confirm, column change and column-change confirm.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `start` is 0, `dout` is 0x00, the command is the main read, the address and its byte count are empty, and the column offset is 0.
- R2: A byte is a command only when `wr_stb`, `cle` and a low `ce_n` coincide. A byte is an address byte when `wr_stb` and `ale` are high and it is not a command. A command byte sent with `ce_n` high changes nothing.
- R3: Address bytes are assembled little-endian, with the first byte at bits 7:0. The low 8 bits (small page) or 16 bits (large page) form the column field. The remaining 16 bits form `row`.
- R4: On a small-page part, a pending read (0x00) or program setup (0x80) dispatches on the 3rd address byte and not before. `op` is 0 for the read and 1 for the program setup.
- R5: On a large-page part, the same operations dispatch on the 4th address byte and not on the 3rd.
- R6: 0x01 presets a column offset of 0x100, 0x50 presets an offset equal to the page size, and 0x00 sets the offset to zero. All three then act as the main read. The offset is added to `col` at the next read or program-setup dispatch, and that dispatch clears it. The offset stays set through a later 0x80.
- R7: 0x90 followed by one address byte loads a 4-byte reply, read in this order: maker code, device code, filler code, then 0x15 on a large-page part or 0xC0 on a small-page part.
- R8: After 0x70 the next read byte is the status byte. Bit 7 is the live value of `wp_n`, and bit 0 is the refused-write flag. All other bits are 0.
- R9: Program confirm 0x10 (`op` 2, with the setup's row and column) and erase confirm 0xD0 (`op` 3, row = low 16 address bits, `col` 0) dispatch only while `wp_n` is high. While `wp_n` is low they dispatch nothing and set status bit 0.
- R10: 0xFF returns the command to the main read and clears the address, the byte count, the offset, the pending reply and status bit 0.
- R11: On a large-page part, 0x30 after a read is ignored. 0x05 clears only the column field and restarts the byte count. 0xE0 dispatches a read (`op` 0) at the held row and column field, with no offset.
- R12: `dout` is 0x00 while `ce_n` is high or when no reply bytes are left. A read strobe with `ce_n` high does not advance the reply. Unknown bytes, including 0x30, 0x05 and 0xE0 on a small-page part, dispatch nothing, and later address bytes dispatch nothing either.
- R13: `start` is high for exactly the one cycle after the strobe that dispatches the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe: the bus byte is taken this cycle |
| cle | input | 1 | Command-latch enable |
| ale | input | 1 | Address-latch enable |
| ce_n | input | 1 | Chip enable, active low |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Byte on the bus |
| rd_stb | input | 1 | Read strobe: moves the reply to its next byte |
| dout | output | 8 | Current reply byte |
| start | output | 1 | One-cycle dispatch pulse to page storage |
| op | output | 2 | 0 read, 1 program setup, 2 program commit, 3 erase |
| row | output | ROW_W | Page row for the dispatched operation |
| col | output | COL_W | Column for the dispatched operation |

## Verification
A table of write cycles runs the small-page part through each offset preset, a program setup and commit with and without a carried offset, and a block erase. It shows that the dispatch point, the byte order and the offset sum are each correct. Directed sequences then drive a large-page part through the same read and through column changes. This separates the 3-byte and 4-byte dispatch rules and shows that 0x05 and 0xE0 keep the row. Toggling `wp_n` around the confirm commands and around a pending status byte separates refused writes from a live bit 7. Chip-enable-high commands, unknown codes, reads past the end of the reply and a reset after a partial address show which inputs must change nothing.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        CS_READ,
        CS_PROG,
        CS_ERASE,
        CS_ID,
        CS_IDLE
    } cmd_state_e;

    typedef enum logic [1:0] {
        OP_READ        = 2'd0,
        OP_PROG_SETUP  = 2'd1,
        OP_PROG_COMMIT = 2'd2,
        OP_ERASE       = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_ID,
        RS_STATUS
    } resp_e;

    typedef enum logic [3:0] {
        K_READ_MAIN,
        K_READ_UPPER,
        K_READ_SPARE,
        K_IDENT,
        K_RESET,
        K_PROG_SETUP,
        K_PROG_CONFIRM,
        K_ERASE_SETUP,
        K_ERASE_CONFIRM,
        K_STATUS,
        K_READ_CONFIRM,
        K_COL_CHANGE,
        K_COL_CONFIRM,
        K_UNKNOWN
    } cmd_kind_e;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_seq_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b0
) (
    input  logic [7:0] code,
    output cmd_kind_e  kind
);
    // Large-page-only commands fall to unknown on a small-page part
    localparam cmd_kind_e LP_RDCONF  = LARGE_PAGE ? K_READ_CONFIRM : K_UNKNOWN;
    localparam cmd_kind_e LP_COLCHG  = LARGE_PAGE ? K_COL_CHANGE   : K_UNKNOWN;
    localparam cmd_kind_e LP_COLCONF = LARGE_PAGE ? K_COL_CONFIRM  : K_UNKNOWN;

    always_comb begin
        case (code)
            8'h00:   kind = K_READ_MAIN;
            8'h01:   kind = K_READ_UPPER;
            8'h50:   kind = K_READ_SPARE;
            8'h90:   kind = K_IDENT;
            8'hFF:   kind = K_RESET;
            8'h80:   kind = K_PROG_SETUP;
            8'h10:   kind = K_PROG_CONFIRM;
            8'h60:   kind = K_ERASE_SETUP;
            8'hD0:   kind = K_ERASE_CONFIRM;
            8'h70:   kind = K_STATUS;
            8'h30:   kind = LP_RDCONF;
            8'h05:   kind = LP_COLCHG;
            8'hE0:   kind = LP_COLCONF;
            default: kind = K_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/nand_resp_mux.sv
module nand_resp_mux
    import nand_seq_pkg::*;
#(
    parameter bit         LARGE_PAGE  = 1'b0,
    parameter logic [7:0] MAKER_CODE  = 8'hEC,
    parameter logic [7:0] DEVICE_CODE = 8'h73,
    parameter logic [7:0] FILLER_CODE = 8'hA5
) (
    input  resp_e       kind,
    input  logic [1:0]  idx,
    input  logic [2:0]  left,
    input  logic        ce_n,
    input  logic        wp_n,
    input  logic        err,
    output logic [7:0]  byte_o
);
    localparam logic [7:0] GEOM_CODE = LARGE_PAGE ? 8'h15 : 8'hC0;

    always_comb begin
        byte_o = 8'h00;
        if (!ce_n && left != 3'd0) begin
            case (kind)
                RS_ID: begin
                    case (idx)
                        2'd0:    byte_o = MAKER_CODE;
                        2'd1:    byte_o = DEVICE_CODE;
                        2'd2:    byte_o = FILLER_CODE;
                        default: byte_o = GEOM_CODE;
                    endcase
                end
                RS_STATUS: byte_o = {wp_n, 6'b0, err};
                default:   byte_o = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter bit         LARGE_PAGE  = 1'b0,
    parameter int         ROW_W       = 16,
    parameter int         COL_W       = 12,
    parameter logic [7:0] MAKER_CODE  = 8'hEC,
    parameter logic [7:0] DEVICE_CODE = 8'h73,
    parameter logic [7:0] FILLER_CODE = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             cle,
    input  logic             ale,
    input  logic             ce_n,
    input  logic             wp_n,
    input  logic [7:0]       din,
    input  logic             rd_stb,
    output logic [7:0]       dout,
    output logic             start,
    output logic [1:0]       op,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam int ADDR_BYTES = LARGE_PAGE ? 4 : 3;
    localparam int COL_BYTES  = LARGE_PAGE ? 2 : 1;
    localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int COL_BITS   = 8 * COL_BYTES;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(ADDR_BYTES);
    localparam logic [COL_W-1:0] OFFS_UPPER = COL_W'(256);
    localparam logic [COL_W-1:0] OFFS_SPARE = COL_W'(PAGE_BYTES);

    typedef struct packed {
        cmd_state_e        cmd;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [COL_W-1:0]  offs;
        resp_e             resp;
        logic [1:0]        idx;
        logic [2:0]        left;
        logic              err;
        logic              start;
        op_e               op;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } seq_t;

    localparam seq_t SEQ_RST = '{cmd: CS_READ, resp: RS_NONE, op: OP_READ, default: '0};

    seq_t              s_d, s_q;
    cmd_kind_e         kind;
    logic              cmd_hit, adr_hit;
    logic [ADDR_W-1:0] addr_n;
    logic [CNT_W-1:0]  cnt_n;

    nand_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
        .code (din),
        .kind (kind)
    );

    nand_resp_mux #(
        .LARGE_PAGE  (LARGE_PAGE),
        .MAKER_CODE  (MAKER_CODE),
        .DEVICE_CODE (DEVICE_CODE),
        .FILLER_CODE (FILLER_CODE)
    ) u_resp (
        .kind   (s_q.resp),
        .idx    (s_q.idx),
        .left   (s_q.left),
        .ce_n   (ce_n),
        .wp_n   (wp_n),
        .err    (s_q.err),
        .byte_o (dout)
    );

    assign cmd_hit = wr_stb && !ce_n && cle;
    assign adr_hit = wr_stb && ale && !cmd_hit;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        addr_n    = s_q.addr;
        cnt_n     = s_q.cnt;

        // reply read side; a write in the same cycle may override below
        if (rd_stb && !ce_n && s_q.left != 3'd0) begin
            s_d.left = s_q.left - 3'd1;
            s_d.idx  = s_q.idx + 2'd1;
        end

        if (cmd_hit) begin
            case (kind)
                K_RESET: s_d = SEQ_RST;
                K_COL_CHANGE: begin
                    s_d.addr[COL_BITS-1:0] = '0;
                    s_d.cnt                = '0;
                end
                K_COL_CONFIRM: begin
                    s_d.cmd   = CS_IDLE;
                    s_d.resp  = RS_NONE;
                    s_d.left  = 3'd0;
                    s_d.start = 1'b1;
                    s_d.op    = OP_READ;
                    s_d.row   = ROW_W'(s_q.addr[ADDR_W-1:COL_BITS]);
                    s_d.col   = COL_W'(s_q.addr[COL_BITS-1:0]);
                end
                K_READ_CONFIRM: begin
                    if (s_q.cmd != CS_READ) begin
                        s_d.cmd  = CS_IDLE;
                        s_d.addr = '0;
                        s_d.cnt  = '0;
                        s_d.resp = RS_NONE;
                        s_d.left = 3'd0;
                    end
                end
                default: begin
                    s_d.addr = '0;
                    s_d.cnt  = '0;
                    s_d.resp = RS_NONE;
                    s_d.left = 3'd0;
                    s_d.cmd  = CS_IDLE;
                    case (kind)
                        K_READ_MAIN: begin
                            s_d.cmd  = CS_READ;
                            s_d.offs = '0;
                        end
                        K_READ_UPPER: begin
                            s_d.cmd  = CS_READ;
                            s_d.offs = OFFS_UPPER;
                        end
                        K_READ_SPARE: begin
                            s_d.cmd  = CS_READ;
                            s_d.offs = OFFS_SPARE;
                        end
                        K_IDENT:       s_d.cmd = CS_ID;
                        K_PROG_SETUP:  s_d.cmd = CS_PROG;
                        K_ERASE_SETUP: s_d.cmd = CS_ERASE;
                        K_STATUS: begin
                            s_d.resp = RS_STATUS;
                            s_d.left = 3'd1;
                            s_d.idx  = 2'd0;
                        end
                        K_PROG_CONFIRM: begin
                            if (wp_n) begin
                                s_d.start = 1'b1;
                                s_d.op    = OP_PROG_COMMIT;
                                s_d.row   = ROW_W'(s_q.addr[ADDR_W-1:COL_BITS]);
                                s_d.col   = s_q.col;
                            end else begin
                                s_d.err = 1'b1;
                            end
                        end
                        K_ERASE_CONFIRM: begin
                            if (wp_n) begin
                                s_d.start = 1'b1;
                                s_d.op    = OP_ERASE;
                                s_d.row   = ROW_W'(s_q.addr);
                                s_d.col   = '0;
                            end else begin
                                s_d.err = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end else if (adr_hit) begin
            if (s_q.cnt < CNT_MAX) begin
                addr_n = s_q.addr | ({{(ADDR_W-8){1'b0}}, din} << (8 * s_q.cnt));
                cnt_n  = s_q.cnt + 1'b1;
            end
            s_d.addr = addr_n;
            s_d.cnt  = cnt_n;
            if (s_q.cmd == CS_ID && s_q.cnt == '0) begin
                s_d.resp = RS_ID;
                s_d.idx  = 2'd0;
                s_d.left = 3'd4;
            end
            if (cnt_n == CNT_MAX && s_q.cnt != CNT_MAX &&
                (s_q.cmd == CS_READ || s_q.cmd == CS_PROG)) begin
                s_d.start = 1'b1;
                s_d.op    = (s_q.cmd == CS_READ) ? OP_READ : OP_PROG_SETUP;
                s_d.row   = ROW_W'(addr_n[ADDR_W-1:COL_BITS]);
                s_d.col   = COL_W'(addr_n[COL_BITS-1:0]) + s_q.offs;
                s_d.offs  = '0;
                s_d.resp  = RS_NONE;
                s_d.left  = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign start = s_q.start;
    assign op    = s_q.op;
    assign row   = s_q.row;
    assign col   = s_q.col;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       cle,
    input logic       ale,
    input logic       ce_n,
    input logic       wp_n,
    input logic       start,
    input logic [1:0] op,
    input logic [7:0] dout
);
    // R2: a deselected command cycle with no address latch dispatches nothing
    p_deselected_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb && ce_n && cle && !ale) |-> !start);

    // R4: program setup is only ever dispatched by an address byte
    p_setup_from_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'd1) |-> $past(ale && wr_stb));

    // R9: commit and erase never dispatch while write protected
    p_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 2'd2 || op == 2'd3)) |-> $past(wp_n));

    // R12: deselected part drives zero
    p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> dout == 8'h00);

    // R13: every pulse follows a write strobe one cycle earlier
    p_pulse_after_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_stb));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .cle    (cle),
    .ale    (ale),
    .ce_n   (ce_n),
    .wp_n   (wp_n),
    .start  (start),
    .op     (op),
    .dout   (dout)
);

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n, wr_stb, cle, ale, ce_n, wp_n, rd_stb;
    logic [7:0]  din;
    logic [7:0]  dout_s, dout_l;
    logic        start_s, start_l;
    logic [1:0]  op_s, op_l;
    logic [15:0] row_s, row_l;
    logic [11:0] col_s, col_l;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    nand_cmd_seq #(.LARGE_PAGE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
        .ce_n(ce_n), .wp_n(wp_n), .din(din), .rd_stb(rd_stb),
        .dout(dout_s), .start(start_s), .op(op_s), .row(row_s), .col(col_s)
    );

    nand_cmd_seq #(.LARGE_PAGE(1'b1), .DEVICE_CODE(8'hF1)) dut_lp (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
        .ce_n(ce_n), .wp_n(wp_n), .din(din), .rd_stb(rd_stb),
        .dout(dout_l), .start(start_l), .op(op_l), .row(row_l), .col(col_l)
    );

    // vector: cle, ale, byte, expected start, op, row, col
    function automatic logic [40:0] mk(input logic c, input logic a, input logic [7:0] b,
                                       input logic s, input logic [1:0] o,
                                       input logic [15:0] r, input logic [11:0] k);
        return {c, a, b, s, o, r, k};
    endfunction

    localparam int NV = 27;
    localparam logic [40:0] VECS [0:NV-1] = '{
        mk(1, 0, 8'h00, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h10, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h34, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h12, 1, 0, 16'h1234, 12'h010),
        mk(1, 0, 8'h01, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h05, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h02, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h00, 1, 0, 16'h0002, 12'h105),
        mk(1, 0, 8'h50, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h03, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h01, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h00, 1, 0, 16'h0001, 12'h203),
        mk(1, 0, 8'h80, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h20, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h05, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h00, 1, 1, 16'h0005, 12'h020),
        mk(1, 0, 8'h10, 1, 2, 16'h0005, 12'h020),
        mk(1, 0, 8'h60, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h40, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h00, 0, 0, 16'h0000, 12'h000),
        mk(1, 0, 8'hD0, 1, 3, 16'h0040, 12'h000),
        mk(1, 0, 8'h50, 0, 0, 16'h0000, 12'h000),
        mk(1, 0, 8'h80, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h04, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h09, 0, 0, 16'h0000, 12'h000),
        mk(0, 1, 8'h00, 1, 1, 16'h0009, 12'h204),
        mk(1, 0, 8'h10, 1, 2, 16'h0009, 12'h204)
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one write cycle; called at a falling edge, returns at the next one
    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; din = b; wr_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd(output logic [7:0] vs, output logic [7:0] vl);
        vs = dout_s; vl = dout_l; rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] vs, vl;
        rst_n = 1'b0; wr_stb = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
        wp_n = 1'b1; rd_stb = 1'b0; din = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 start after reset", 32'(start_s), 32'd0);
        chk("R1 dout after reset", 32'(dout_s), 32'h00);

        // R3 R4 R6 R9: table of write cycles on the small-page part
        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            v = VECS[i];
            wr(v[40], v[39], v[38:31]);
            chk($sformatf("R4 R6 vector %0d start", i), 32'(start_s), 32'(v[30]));
            if (v[30]) begin
                chk($sformatf("R3 vector %0d op", i), 32'(op_s), 32'(v[29:28]));
                chk($sformatf("R3 R6 vector %0d row", i), 32'(row_s), 32'(v[27:12]));
                chk($sformatf("R3 R6 vector %0d col", i), 32'(col_s), 32'(v[11:0]));
            end
        end
        idle();
        chk("R13 pulse lasts one cycle", 32'(start_s), 32'd0);

        // R8 status byte with live write-protect bit
        wr(1, 0, 8'h70);
        chk("R8 status unprotected", 32'(dout_s), 32'h80);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R8 status follows wp_n", 32'(dout_s), 32'h00);
        rd(vs, vl);
        wp_n = 1'b1;
        chk("R12 exhausted status", 32'(dout_s), 32'h00);

        // R7 identification reply on both geometries
        wr(1, 0, 8'h90);
        wr(0, 1, 8'h00);
        rd(vs, vl); chk("R7 maker byte", 32'(vs), 32'hEC);
        rd(vs, vl); chk("R7 device byte", 32'(vs), 32'h73);
        chk("R7 large device byte", 32'(vl), 32'hF1);
        rd(vs, vl); chk("R7 filler byte", 32'(vs), 32'hA5);
        rd(vs, vl); chk("R7 small geometry byte", 32'(vs), 32'hC0);
        chk("R7 large geometry byte", 32'(vl), 32'h15);
        chk("R12 past end of reply", 32'(dout_s), 32'h00);

        // R12 deselected read neither drives nor advances
        wr(1, 0, 8'h90);
        wr(0, 1, 8'h00);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R12 dout with ce_n high", 32'(dout_s), 32'h00);
        rd(vs, vl);
        ce_n = 1'b0;
        @(negedge clk);
        chk("R12 deselected read did not advance", 32'(dout_s), 32'hEC);

        // R2 command with ce_n high is ignored
        wr(1, 0, 8'h00);
        ce_n = 1'b1;
        wr(1, 0, 8'h90);
        ce_n = 1'b0;
        wr(0, 1, 8'h01);
        wr(0, 1, 8'h02);
        chk("R2 R4 no dispatch on 2nd byte", 32'(start_s), 32'd0);
        wr(0, 1, 8'h03);
        chk("R2 read still pending", 32'(start_s), 32'd1);
        chk("R2 R3 row", 32'(row_s), 32'h0302);
        chk("R2 R3 col", 32'(col_s), 32'h001);

        // R9 write protect refuses confirms and flags status bit 0
        wp_n = 1'b0;
        wr(1, 0, 8'h80);
        wr(0, 1, 8'h00); wr(0, 1, 8'h01); wr(0, 1, 8'h00);
        chk("R9 setup allowed while protected", 32'(start_s), 32'd1);
        wr(1, 0, 8'h10);
        chk("R9 commit refused", 32'(start_s), 32'd0);
        wr(1, 0, 8'h60);
        wr(0, 1, 8'h02); wr(0, 1, 8'h00);
        wr(1, 0, 8'hD0);
        chk("R9 erase refused", 32'(start_s), 32'd0);
        wr(1, 0, 8'h70);
        chk("R9 error bit set", 32'(dout_s), 32'h01);
        wp_n = 1'b1;
        @(negedge clk);
        chk("R8 bit 7 back high", 32'(dout_s), 32'h81);

        // R10 reset clears error, offset and partial address
        wr(1, 0, 8'hFF);
        wr(1, 0, 8'h70);
        chk("R10 error cleared", 32'(dout_s), 32'h80);
        wr(1, 0, 8'h01);
        wr(0, 1, 8'h11);
        wr(1, 0, 8'hFF);
        wr(0, 1, 8'h22); wr(0, 1, 8'h33); wr(0, 1, 8'h44);
        chk("R10 read dispatch after reset", 32'(start_s), 32'd1);
        chk("R10 row from fresh count", 32'(row_s), 32'h4433);
        chk("R10 offset cleared", 32'(col_s), 32'h022);

        // R12 unknown codes dispatch nothing
        wr(1, 0, 8'hAB);
        wr(0, 1, 8'h01); wr(0, 1, 8'h02); wr(0, 1, 8'h03);
        chk("R12 unknown code then address", 32'(start_s), 32'd0);
        wr(1, 0, 8'hE0);
        chk("R12 0xE0 on small page", 32'(start_s), 32'd0);

        // R5 R11 large-page part
        wr(1, 0, 8'h00);
        wr(0, 1, 8'h34); wr(0, 1, 8'h02); wr(0, 1, 8'h78);
        chk("R5 no dispatch on 3rd byte", 32'(start_l), 32'd0);
        wr(0, 1, 8'h56);
        chk("R5 dispatch on 4th byte", 32'(start_l), 32'd1);
        chk("R5 R3 large row", 32'(row_l), 32'h5678);
        chk("R5 R3 large col", 32'(col_l), 32'h234);
        wr(1, 0, 8'h30);
        chk("R11 read confirm ignored", 32'(start_l), 32'd0);
        wr(1, 0, 8'h05);
        wr(0, 1, 8'h10); wr(0, 1, 8'h01);
        chk("R11 column change no dispatch", 32'(start_l), 32'd0);
        wr(1, 0, 8'hE0);
        chk("R11 column confirm dispatch", 32'(start_l), 32'd1);
        chk("R11 op read", 32'(op_l), 32'd0);
        chk("R11 row kept", 32'(row_l), 32'h5678);
        chk("R11 new column", 32'(col_l), 32'h110);
        wr(1, 0, 8'h60);
        wr(0, 1, 8'h07); wr(0, 1, 8'h00);
        wr(1, 0, 8'hD0);
        chk("R9 large erase op", 32'(op_l), 32'd3);
        chk("R9 large erase row", 32'(row_l), 32'h0007);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule